// File: doc/BRIEF.md
# Geometry Coprocessor Register File

This block is the 64-entry, 32-bit architectural register file of a geometry coprocessor. It has one synchronous write port (enable, index, data) and one combinational read port (index, data). The index decides what a write does. Some entries keep only the low half of the data and widen it with sign or zero extension. Two entries ignore writes. One write index feeds a three-entry screen-coordinate FIFO, and every other index stores the word unchanged.

Three indices need extra work after a write, such as colour packing, a leading-zero count or flag masking. The file stores the raw word for them and raises a one-cycle strobe carrying the index, so that logic outside this block can do that work. Reads return the stored contents, with two exceptions. The FIFO push index reads back as the newest FIFO entry, and the two colour indices read from an external packed-colour input.

Top module: `cop_regfile`

## Requirements
- R1: A clock edge with `rst_n` low clears all 64 registers to zero, so afterwards every index reads 0 except 28 and 29.
- R2: A write to index 1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61 or 62 stores bits 15:0 of the data, sign-extended from bit 15 to 32 bits.
- R3: A write to index 7, 16, 17, 18 or 19 stores bits 15:0 of the data, zero-extended to 32 bits.
- R4: A write to index 15 shifts the FIFO in a single edge: register 12 takes the old value of 13, register 13 takes the old value of 14, and register 14 takes the full 32-bit data.
- R5: Reading index 15 returns the current contents of register 14.
- R6: Writes to index 29 and index 31 change no register and raise no strobe.
- R7: A write to any index not named in R2, R3, R4, R6 or R8 stores the full 32-bit word unchanged.
- R8: A write to index 28, 30 or 63 stores the full 32-bit word. In the cycle after that edge, `fx_valid` is 1 and `fx_idx` holds the index. Otherwise `fx_valid` is 0.
- R9: Reading index 28 or 29 returns `color_in` and not the stored value.
- R10: A read in the same cycle as a write to the same index returns the value from before the write. The new value is visible from the cycle after the edge.
- R11: With `wr_en` low, no register changes whatever `wr_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write index |
| wr_data | input | 32 | Write data |
| rd_idx | input | 6 | Read index |
| rd_data | output | 32 | Read data, combinational from `rd_idx` |
| color_in | input | 32 | Externally packed colour word, returned for reads of 28 and 29 |
| fx_valid | output | 1 | One-cycle strobe after a write that needs extra handling |
| fx_idx | output | 6 | Index that caused the strobe |

## Verification
The read port has no register in its path, so `rd_data` is due a settling delay after `rd_idx` or `color_in` changes, in the same cycle. A write is due on the read port one cycle after the rising edge that takes it, and `fx_valid`/`fx_idx` are due in that same following cycle and clear one edge later. The bench drives inputs at the falling edge and checks read data 1 ns after it changes. It checks write results and the strobe at the falling edge after the capturing rising edge. For same-cycle behaviour it reads the old value before that rising edge. For the strobe it checks a second time one cycle later to confirm that the pulse has dropped.

// File: rtl/cop_regs_pkg.sv
// Package: cop_regs_pkg
// Shared sizes, fixed register indices and the per-index write rule
// of the geometry coprocessor register file.
// Assumes a 64-entry file: the index constants below are fixed by the
// coprocessor's programming model and are not scaled by parameters.
package cop_regs_pkg;

    localparam int NUM_REGS  = 64;
    localparam int DATA_W    = 32;

    // Screen-coordinate FIFO entries, oldest to newest, and its push port
    localparam int FIFO_OLD  = 12;
    localparam int FIFO_MID  = 13;
    localparam int FIFO_NEW  = 14;
    localparam int FIFO_PUSH = 15;

    // Indices whose reads come from the external colour input
    localparam int COLOR_A   = 28;
    localparam int COLOR_B   = 29;

    // What a write at a given index does
    typedef enum logic [2:0] {
        WK_PLAIN = 3'd0,   // full word stored
        WK_SEXT  = 3'd1,   // low half, sign-extended
        WK_ZEXT  = 3'd2,   // low half, zero-extended
        WK_PUSH  = 3'd3,   // FIFO push
        WK_DROP  = 3'd4,   // read-only, write ignored
        WK_SIDE  = 3'd5    // full word stored, side-effect strobe
    } wkind_e;

    // Map an index to its write rule
    function automatic wkind_e classify(input int unsigned idx);
        wkind_e k;
        case (idx)
            1, 3, 5, 8, 9, 10, 11,
            36, 44, 52, 58, 59, 61, 62: k = WK_SEXT;
            7, 16, 17, 18, 19:          k = WK_ZEXT;
            15:                         k = WK_PUSH;
            29, 31:                     k = WK_DROP;
            28, 30, 63:                 k = WK_SIDE;
            default:                    k = WK_PLAIN;
        endcase
        return k;
    endfunction

    // True when a read of idx returns the external colour word
    function automatic logic reads_color(input int unsigned idx);
        return (idx == COLOR_A) || (idx == COLOR_B);
    endfunction

endpackage

// File: rtl/cop_wr_decode.sv
// Module: cop_wr_decode
// Turns one write request into a one-hot store select, the data word
// shaped for the index's rule, a FIFO push request and a side-effect hit.
// Purely combinational. Assumes NREGS covers every index that
// cop_regs_pkg::classify names.
module cop_wr_decode
    import cop_regs_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(NREGS),
    localparam int HALF = DW / 2
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    output logic [NREGS-1:0] sel,
    output logic [DW-1:0]    store_data,
    output logic             push,
    output logic             side_hit
);

    wkind_e kind;

    // Look up the rule for the requested index
    always_comb kind = classify(32'(wr_idx));

    // Shape the data word the way the rule asks
    always_comb begin
        case (kind)
            WK_SEXT: store_data = {{(DW-HALF){wr_data[HALF-1]}}, wr_data[HALF-1:0]};
            WK_ZEXT: store_data = {{(DW-HALF){1'b0}}, wr_data[HALF-1:0]};
            default: store_data = wr_data;
        endcase
    end

    // Select the one entry that stores; pushes and ignored writes select none
    always_comb begin
        sel = '0;
        if (wr_en && (kind != WK_PUSH) && (kind != WK_DROP))
            sel[wr_idx] = 1'b1;
    end

    // Flag the FIFO push and the side-effect indices
    always_comb begin
        push     = wr_en && (kind == WK_PUSH);
        side_hit = wr_en && (kind == WK_SIDE);
    end

endmodule

// File: rtl/cop_reg_array.sv
// Module: cop_reg_array
// The storage itself: NREGS words, each with its own update process.
// The three FIFO entries also shift when a push arrives. Synchronous
// active-low reset clears every word. Assumes the decoder never selects
// an entry in the same cycle as a push (push selects nothing).
module cop_reg_array
    import cop_regs_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int DW    = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREGS-1:0]          sel,
    input  logic [DW-1:0]             store_data,
    input  logic                      push,
    output logic [NREGS-1:0][DW-1:0]  regs_q
);

    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        logic [DW-1:0] q;

        if (i == FIFO_OLD) begin : g_old
            // Oldest FIFO entry: takes the middle entry on a push
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= '0;
                else if (push)   q <= regs_q[FIFO_MID];
                else if (sel[i]) q <= store_data;
            end
        end else if (i == FIFO_MID) begin : g_mid
            // Middle FIFO entry: takes the newest entry on a push
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= '0;
                else if (push)   q <= regs_q[FIFO_NEW];
                else if (sel[i]) q <= store_data;
            end
        end else if (i == FIFO_NEW) begin : g_new
            // Newest FIFO entry: takes the pushed word
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= '0;
                else if (push)   q <= store_data;
                else if (sel[i]) q <= store_data;
            end
        end else begin : g_plain
            // Ordinary entry: stores the shaped word when selected
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= '0;
                else if (sel[i]) q <= store_data;
            end
        end

        assign regs_q[i] = q;
    end

endmodule

// File: rtl/cop_rd_mux.sv
// Module: cop_rd_mux
// Combinational read port. Applies the FIFO alias (the push index reads
// the newest entry) and the colour override. Assumes regs_q is the
// registered state, so a same-cycle write is not visible here.
module cop_rd_mux
    import cop_regs_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic [NREGS-1:0][DW-1:0] regs_q,
    input  logic [AW-1:0]            rd_idx,
    input  logic [DW-1:0]            color_in,
    output logic [DW-1:0]            rd_data
);

    // Pick the word for the requested index
    always_comb begin
        if (reads_color(32'(rd_idx)))
            rd_data = color_in;
        else if (32'(rd_idx) == FIFO_PUSH)
            rd_data = regs_q[FIFO_NEW];
        else
            rd_data = regs_q[rd_idx];
    end

endmodule

// File: rtl/cop_side_strobe.sv
// Module: cop_side_strobe
// Registers the side-effect hit into a one-cycle strobe with its index,
// aligned with the cycle in which the stored raw word becomes readable.
module cop_side_strobe #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          side_hit,
    input  logic [AW-1:0] wr_idx,
    output logic          fx_valid,
    output logic [AW-1:0] fx_idx
);

    // Capture the hit and its index for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx_valid <= 1'b0;
            fx_idx   <= '0;
        end else begin
            fx_valid <= side_hit;
            fx_idx   <= side_hit ? wr_idx : '0;
        end
    end

endmodule

// File: rtl/cop_regfile.sv
// Module: cop_regfile
// Top of the coprocessor register file: per-index write rules, a
// three-entry coordinate FIFO, a read alias and colour override, and a
// side-effect strobe for indices that outside logic post-processes.
// Assumes one write and one read per cycle; reads see pre-write state.
module cop_regfile
    import cop_regs_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] color_in,
    output logic          fx_valid,
    output logic [AW-1:0] fx_idx
);

    logic [NREGS-1:0]         sel;
    logic [DW-1:0]            store_data;
    logic                     push;
    logic                     side_hit;
    logic [NREGS-1:0][DW-1:0] regs_q;

    cop_wr_decode #(.NREGS(NREGS), .DW(DW)) u_dec (
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .sel        (sel),
        .store_data (store_data),
        .push       (push),
        .side_hit   (side_hit)
    );

    cop_reg_array #(.NREGS(NREGS), .DW(DW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .store_data (store_data),
        .push       (push),
        .regs_q     (regs_q)
    );

    cop_rd_mux #(.NREGS(NREGS), .DW(DW)) u_rd (
        .regs_q   (regs_q),
        .rd_idx   (rd_idx),
        .color_in (color_in),
        .rd_data  (rd_data)
    );

    cop_side_strobe #(.AW(AW)) u_fx (
        .clk      (clk),
        .rst_n    (rst_n),
        .side_hit (side_hit),
        .wr_idx   (wr_idx),
        .fx_valid (fx_valid),
        .fx_idx   (fx_idx)
    );

endmodule

// File: rtl/cop_regfile_chk.sv
// Module: cop_regfile_chk
// Assertion checker bound into cop_regfile. It watches the ports and the
// registered state and tracks the previous write in its own registers.
module cop_regfile_chk
    import cop_regs_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(NREGS),
    localparam int HALF = DW / 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [AW-1:0]            wr_idx,
    input logic [DW-1:0]            wr_data,
    input logic [AW-1:0]            rd_idx,
    input logic [DW-1:0]            rd_data,
    input logic [DW-1:0]            color_in,
    input logic                     fx_valid,
    input logic [AW-1:0]            fx_idx,
    input logic [NREGS-1:0][DW-1:0] regs
);

    logic          prev_en;
    logic [AW-1:0] prev_idx;
    logic [DW-1:0] prev_data;

    // Remember the last accepted write request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_idx  <= '0;
            prev_data <= '0;
        end else begin
            prev_en   <= wr_en;
            prev_idx  <= wr_idx;
            prev_data <= wr_data;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (regs == '0));

    // R2
    sext_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_en && classify(32'(prev_idx)) == WK_SEXT) |->
        regs[prev_idx] == {{(DW-HALF){prev_data[HALF-1]}}, prev_data[HALF-1:0]});

    // R3
    zext_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_en && classify(32'(prev_idx)) == WK_ZEXT) |->
        regs[prev_idx] == {{(DW-HALF){1'b0}}, prev_data[HALF-1:0]});

    // R4
    fifo_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(wr_idx) == FIFO_PUSH) |=>
        (regs[FIFO_OLD] == $past(regs[FIFO_MID])) &&
        (regs[FIFO_MID] == $past(regs[FIFO_NEW])) &&
        (regs[FIFO_NEW] == $past(wr_data)));

    // R5
    fifo_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_idx) == FIFO_PUSH) |-> rd_data == regs[FIFO_NEW]);

    // R6
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && classify(32'(wr_idx)) == WK_DROP) |=> ($stable(regs) && !fx_valid));

    // R8
    fx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && classify(32'(wr_idx)) == WK_SIDE) |=>
        (fx_valid && fx_idx == $past(wr_idx) && regs[fx_idx] == $past(wr_data)));

    // R8
    fx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fx_valid |-> classify(32'(fx_idx)) == WK_SIDE);

    // R9
    color_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reads_color(32'(rd_idx)) |-> rd_data == color_in);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

endmodule

bind cop_regfile cop_regfile_chk #(.NREGS(NREGS), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .color_in (color_in),
    .fx_valid (fx_valid),
    .fx_idx   (fx_idx),
    .regs     (regs_q)
);

// File: tb/cop_regfile_bench.sv
`timescale 1ns/1ps
// Directed bench for cop_regfile: one task per scenario, each checks itself.
module cop_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [31:0] color_in = 32'h00A1_B2C3;
    logic        fx_valid;
    logic [5:0]  fx_idx;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cop_regfile u_cop_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .color_in(color_in), .fx_valid(fx_valid), .fx_idx(fx_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational read, sampled 1 ns after the index settles
    task automatic read_chk(input string req, input int idx, input logic [31:0] exp);
        rd_idx = 6'(idx);
        #1;
        check(req, rd_data, exp);
    endtask

    // One write, returns at the falling edge after the capturing edge
    task automatic write(input int idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    endtask

    task automatic t_reset;
        read_chk("R1 idx0", 0, 32'h0);
        read_chk("R1 idx12", 12, 32'h0);
        read_chk("R1 idx15", 15, 32'h0);
        read_chk("R1 idx31", 31, 32'h0);
        read_chk("R1 idx63", 63, 32'h0);
        check("R8 fx idle after reset", {31'b0, fx_valid}, 32'h0);
    endtask

    task automatic t_sext;
        write(8, 32'h1234_8001);  read_chk("R2 idx8 neg", 8, 32'hFFFF_8001);
        write(62, 32'hABCD_7FFF); read_chk("R2 idx62 pos", 62, 32'h0000_7FFF);
        write(1, 32'h0000_FFFF);  read_chk("R2 idx1 all ones", 1, 32'hFFFF_FFFF);
        write(36, 32'h5555_8000); read_chk("R2 idx36", 36, 32'hFFFF_8000);
    endtask

    task automatic t_zext;
        write(7, 32'hDEAD_8001);  read_chk("R3 idx7", 7, 32'h0000_8001);
        write(19, 32'hFFFF_FFFF); read_chk("R3 idx19", 19, 32'h0000_FFFF);
        write(16, 32'h8000_1234); read_chk("R3 idx16", 16, 32'h0000_1234);
    endtask

    task automatic t_plain;
        write(0, 32'hCAFE_BABE);  read_chk("R7 idx0", 0, 32'hCAFE_BABE);
        write(6, 32'h1234_ABCD);  read_chk("R7 idx6", 6, 32'h1234_ABCD);
        write(20, 32'h8000_8000); read_chk("R7 idx20", 20, 32'h8000_8000);
        write(2, 32'hFFFF_0001);  read_chk("R7 idx2", 2, 32'hFFFF_0001);
        check("R8 no strobe on plain", {31'b0, fx_valid}, 32'h0);
    endtask

    task automatic t_fifo;
        write(15, 32'hA000_000A);
        write(15, 32'hB000_000B);
        write(15, 32'hC000_000C);
        read_chk("R4 old after 3", 12, 32'hA000_000A);
        read_chk("R4 mid after 3", 13, 32'hB000_000B);
        read_chk("R4 new after 3", 14, 32'hC000_000C);
        write(15, 32'hD000_800D);
        read_chk("R4 old after 4", 12, 32'hB000_000B);
        read_chk("R4 mid after 4", 13, 32'hC000_000C);
        read_chk("R4 new full word", 14, 32'hD000_800D);
        read_chk("R5 alias", 15, 32'hD000_800D);
        write(14, 32'h0123_4567);
        read_chk("R5 alias direct", 15, 32'h0123_4567);
        read_chk("R7 direct 14 no shift", 13, 32'hC000_000C);
    endtask

    task automatic t_readonly;
        write(31, 32'hFFFF_FFFF);
        check("R6 no strobe idx31", {31'b0, fx_valid}, 32'h0);
        read_chk("R6 idx31 kept", 31, 32'h0);
        write(29, 32'h1357_9BDF);
        check("R6 no strobe idx29", {31'b0, fx_valid}, 32'h0);
        read_chk("R6 idx28 kept", 28, color_in);
    endtask

    task automatic t_side;
        write(30, 32'h8765_4321);
        check("R8 strobe idx30", {31'b0, fx_valid}, 32'h1);
        check("R8 strobe index 30", {26'b0, fx_idx}, 32'd30);
        read_chk("R8 raw idx30", 30, 32'h8765_4321);
        @(negedge clk);
        check("R8 strobe drops", {31'b0, fx_valid}, 32'h0);
        write(63, 32'hFEDC_0000);
        check("R8 strobe index 63", {26'b0, fx_idx}, 32'd63);
        read_chk("R8 raw idx63", 63, 32'hFEDC_0000);
        write(28, 32'h0BAD_F00D);
        check("R8 strobe index 28", {26'b0, fx_idx}, 32'd28);
    endtask

    task automatic t_color;
        color_in = 32'h00FF_8040;
        read_chk("R9 idx28 color", 28, 32'h00FF_8040);
        read_chk("R9 idx29 color", 29, 32'h00FF_8040);
        color_in = 32'h0012_3456;
        read_chk("R9 idx29 follows", 29, 32'h0012_3456);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        rd_idx = 6'd40;
        wr_en = 1'b1; wr_idx = 6'd40; wr_data = 32'h4040_4040;
        #1;
        check("R10 old before edge", rd_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 new after edge", rd_data, 32'h4040_4040);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 6'd40; wr_data = 32'hDEAD_DEAD;
        @(negedge clk);
        wr_idx = 6'd15; wr_data = 32'hBEEF_BEEF;
        @(negedge clk);
        wr_idx = '0; wr_data = '0;
        read_chk("R11 idx40 held", 40, 32'h4040_4040);
        read_chk("R11 fifo held", 15, 32'h0123_4567);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sext();
        t_zext();
        t_plain();
        t_fifo();
        t_readonly();
        t_side();
        t_color();
        t_same_cycle();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule